// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, every cycle, which of several hardware threads gets the single shared fetch port of a simultaneous-multithreading front end. It tracks how many instructions each thread currently has in flight. Fetches add to that count, and retirements and per-thread flushes subtract from it. In occupancy mode the port goes to the eligible thread holding the fewest in-flight instructions. A stalled thread therefore drops back on its own as its count grows, and it returns once it drains. A round-robin mode ignores occupancy and simply rotates, which makes it a baseline for comparison.

A thread that is spinning can be put to sleep with a quiesce request that names a watch address. It stays out of the competition until a memory write strobe hits that address. A programmable occupancy cap keeps any one thread from filling the window. The grant leaves the block as a valid/ready stream: `fetch_valid` with a one-hot `grant` and `grant_tid`. A fetch is taken only in a cycle where `fetch_valid` and `fetch_ready` are both high. While `fetch_ready` is low, no count is incremented and the rotation does not move. The offered grant may still change under back-pressure, because retirements, flushes and sleeps keep altering eligibility.

Top module: `smt_fetch_sel`

## Requirements
- R1: After reset every count is zero, no thread sleeps and the rotation pointer is 0, so with a nonzero cap the first offer is thread 0 (grant 4'b0001).
- R2: With `rr_mode` low, the granted thread has the smallest count of all eligible threads.
- R3: Among the candidates, the search starts at the rotation pointer and moves upward with wrap. After each accepted fetch the pointer becomes the granted ID plus one, modulo the thread count.
- R4: With `rr_mode` high, counts play no part in the choice: the first eligible thread at or after the pointer wins.
- R5: An accepted fetch adds `fetch_num` to the granted thread's count. `ret_num` is subtracted from thread `ret_tid` only, and `flush_num` from thread `flush_tid` only. All of these apply in the same cycle, with the result saturating at 0 and at 63.
- R6: A thread whose count is greater than or equal to `cap` is ineligible in both modes.
- R7: After `quiesce_req` for a thread, that thread is ineligible from the next cycle on. It stays ineligible until a cycle with `mem_wr_valid` high and `mem_wr_addr` equal to its watch address. A quiesce in the same cycle as a matching write leaves the thread asleep.
- R8: When no thread is eligible, `grant` is zero, `grant_tid` is 0 and `fetch_valid` is low.
- R9: `grant` is one-hot whenever `fetch_valid` is high, and `grant_tid` is the index of its set bit. While `fetch_ready` is low, no count is incremented and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 selects round-robin, 0 selects fewest-in-flight |
| cap | input | 6 | Occupancy limit; count >= cap makes a thread ineligible |
| fetch_ready | input | 1 | Fetch stage accepts the offered grant |
| fetch_num | input | 3 | Instructions fetched on an accepted grant (0..4) |
| ret_valid | input | 1 | Retirement event |
| ret_tid | input | 2 | Thread that retires |
| ret_num | input | 3 | Instructions retired (0..4) |
| flush_valid | input | 1 | Flush event |
| flush_tid | input | 2 | Thread being flushed |
| flush_num | input | 6 | Instructions squashed |
| quiesce_req | input | 1 | Put a thread to sleep |
| quiesce_tid | input | 2 | Thread to put to sleep |
| quiesce_addr | input | 16 | Address that thread watches |
| mem_wr_valid | input | 1 | Memory write strobe |
| mem_wr_addr | input | 16 | Address of the write |
| fetch_valid | output | 1 | A thread is offered the fetch port |
| grant | output | 4 | One-hot offered thread |
| grant_tid | output | 2 | Index of the offered thread |

## Verification
The hardest case to reach is a choice made at the same time by the minimum-count filter, the cap and the rotating tie-break, with sleeping threads removed as well. Random traffic rarely leaves counts equal while the pointer sits on a non-candidate. The stimulus therefore opens with directed sequences that fetch equal bundles into every thread, push one thread up against a small cap, and quiesce all threads before waking them one at a time. After that it runs seeded random traffic. That traffic draws write addresses from a short list shared with the quiesce addresses, so that wake-ups and same-cycle quiesce/write collisions happen often.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  localparam int unsigned DEF_THREADS = 4;
  localparam int unsigned DEF_CNT_W   = 6;
  localparam int unsigned DEF_BUNDLE_W = 3;
  localparam int unsigned DEF_ADDR_W  = 16;

  typedef enum logic {
    POL_OCCUPANCY = 1'b0,
    POL_ROTATE    = 1'b1
  } policy_e;
endpackage

// File: rtl/sfs_occ_ctr.sv
module sfs_occ_ctr #(
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned BUNDLE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc_en,
  input  logic [BUNDLE_W-1:0] inc_num,
  input  logic                ret_en,
  input  logic [BUNDLE_W-1:0] ret_num,
  input  logic                fl_en,
  input  logic [CNT_W-1:0]    fl_num,
  output logic [CNT_W-1:0]    cnt
);
  localparam int unsigned SW = CNT_W + 2;
  localparam logic [SW-1:0] TOP = SW'({CNT_W{1'b1}});

  logic [SW-1:0] up, dn, diff;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    up   = SW'(cnt) + (inc_en ? SW'(inc_num) : '0);
    dn   = (ret_en ? SW'(ret_num) : '0) + (fl_en ? SW'(fl_num) : '0);
    diff = up - dn;
    if (dn >= up)        cnt_nx = '0;
    else if (diff > TOP) cnt_nx = {CNT_W{1'b1}};
    else                 cnt_nx = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/sfs_sleep_slot.sv
module sfs_sleep_slot #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_set,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              asleep
);
  logic [ADDR_W-1:0] watch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep <= 1'b0;
      watch  <= '0;
    end else if (q_set) begin
      asleep <= 1'b1;
      watch  <= q_addr;
    end else if (asleep && wr_valid && (wr_addr == watch)) begin
      asleep <= 1'b0;
    end
  end
endmodule

// File: rtl/sfs_pick.sv
module sfs_pick #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TID_W = 2
) (
  input  logic [NTHR*CNT_W-1:0] cnt_flat,
  input  logic [NTHR-1:0]       elig,
  input  logic                  rr_mode,
  input  logic [TID_W-1:0]      ptr,
  output logic [NTHR-1:0]       grant,
  output logic [TID_W-1:0]      tid,
  output logic                  any
);
  logic [CNT_W-1:0] minc;
  logic [NTHR-1:0]  cand;

  always_comb begin
    minc = '1;
    for (int i = 0; i < int'(NTHR); i++)
      if (elig[i] && (cnt_flat[i*CNT_W +: CNT_W] < minc))
        minc = cnt_flat[i*CNT_W +: CNT_W];
    for (int i = 0; i < int'(NTHR); i++)
      cand[i] = elig[i] && (rr_mode || (cnt_flat[i*CNT_W +: CNT_W] == minc));
  end

  always_comb begin
    grant = '0;
    tid   = '0;
    any   = 1'b0;
    for (int k = 0; k < int'(NTHR); k++) begin
      int idx;
      idx = (int'(ptr) + k) % int'(NTHR);
      if (!any && cand[idx]) begin
        any        = 1'b1;
        grant[idx] = 1'b1;
        tid        = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel
  import smt_fetch_pkg::*;
#(
  parameter int unsigned NTHR     = DEF_THREADS,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned BUNDLE_W = DEF_BUNDLE_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  localparam int unsigned TID_W   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rr_mode,
  input  logic [CNT_W-1:0]    cap,
  input  logic                fetch_ready,
  input  logic [BUNDLE_W-1:0] fetch_num,
  input  logic                ret_valid,
  input  logic [TID_W-1:0]    ret_tid,
  input  logic [BUNDLE_W-1:0] ret_num,
  input  logic                flush_valid,
  input  logic [TID_W-1:0]    flush_tid,
  input  logic [CNT_W-1:0]    flush_num,
  input  logic                quiesce_req,
  input  logic [TID_W-1:0]    quiesce_tid,
  input  logic [ADDR_W-1:0]   quiesce_addr,
  input  logic                mem_wr_valid,
  input  logic [ADDR_W-1:0]   mem_wr_addr,
  output logic                fetch_valid,
  output logic [NTHR-1:0]     grant,
  output logic [TID_W-1:0]    grant_tid
);
  logic [NTHR*CNT_W-1:0] cnt_flat;
  logic [NTHR-1:0]       asleep;
  logic [NTHR-1:0]       elig;
  logic [TID_W-1:0]      ptr;
  logic                  take;
  policy_e               pol;

  assign pol  = policy_e'(rr_mode);
  assign take = fetch_valid && fetch_ready;

  for (genvar t = 0; t < int'(NTHR); t++) begin : g_thr
    sfs_occ_ctr #(.CNT_W(CNT_W), .BUNDLE_W(BUNDLE_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (take && grant[t]),
      .inc_num (fetch_num),
      .ret_en  (ret_valid && (ret_tid == TID_W'(t))),
      .ret_num (ret_num),
      .fl_en   (flush_valid && (flush_tid == TID_W'(t))),
      .fl_num  (flush_num),
      .cnt     (cnt_flat[t*CNT_W +: CNT_W])
    );

    sfs_sleep_slot #(.ADDR_W(ADDR_W)) u_sleep (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_set    (quiesce_req && (quiesce_tid == TID_W'(t))),
      .q_addr   (quiesce_addr),
      .wr_valid (mem_wr_valid),
      .wr_addr  (mem_wr_addr),
      .asleep   (asleep[t])
    );

    assign elig[t] = !asleep[t] && (cnt_flat[t*CNT_W +: CNT_W] < cap);
  end

  sfs_pick #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_pick (
    .cnt_flat (cnt_flat),
    .elig     (elig),
    .rr_mode  (pol == POL_ROTATE),
    .ptr      (ptr),
    .grant    (grant),
    .tid      (grant_tid),
    .any      (fetch_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (take)
      ptr <= (int'(grant_tid) == int'(NTHR) - 1) ? '0 : grant_tid + 1'b1;
  end
endmodule

// File: rtl/smt_fetch_sel_chk.sv
module smt_fetch_sel_chk #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TID_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rr_mode,
  input logic [CNT_W-1:0]      cap,
  input logic                  fetch_valid,
  input logic [NTHR-1:0]       grant,
  input logic [TID_W-1:0]      grant_tid,
  input logic                  quiesce_req,
  input logic [TID_W-1:0]      quiesce_tid,
  input logic [NTHR-1:0]       asleep,
  input logic [NTHR-1:0]       elig,
  input logic [NTHR*CNT_W-1:0] cnt_flat
);
  function automatic logic none_smaller(input logic [NTHR*CNT_W-1:0] c,
                                        input logic [NTHR-1:0] e,
                                        input logic [TID_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(NTHR); i++)
      if (e[i] && (c[i*CNT_W +: CNT_W] < c[int'(w)*CNT_W +: CNT_W])) ok = 1'b0;
    return ok;
  endfunction

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ($onehot0(grant) && grant[grant_tid]));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (grant == '0));

  // R6
  under_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (cnt_flat[int'(grant_tid)*CNT_W +: CNT_W] < cap));

  // R7
  awake_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & asleep) == '0);

  // R7
  quiesce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_req |=> !grant[$past(quiesce_tid)]);

  // R2
  min_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !rr_mode) |-> none_smaller(cnt_flat, elig, grant_tid));
endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rr_mode     (rr_mode),
  .cap         (cap),
  .fetch_valid (fetch_valid),
  .grant       (grant),
  .grant_tid   (grant_tid),
  .quiesce_req (quiesce_req),
  .quiesce_tid (quiesce_tid),
  .asleep      (asleep),
  .elig        (elig),
  .cnt_flat    (cnt_flat)
);

// File: tb/smt_fetch_sel_test.sv
`timescale 1ns/1ps
module smt_fetch_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rr_mode;
  logic [5:0]  cap;
  logic        fetch_ready;
  logic [2:0]  fetch_num;
  logic        ret_valid;
  logic [1:0]  ret_tid;
  logic [2:0]  ret_num;
  logic        flush_valid;
  logic [1:0]  flush_tid;
  logic [5:0]  flush_num;
  logic        quiesce_req;
  logic [1:0]  quiesce_tid;
  logic [15:0] quiesce_addr;
  logic        mem_wr_valid;
  logic [15:0] mem_wr_addr;
  logic        fetch_valid;
  logic [3:0]  grant;
  logic [1:0]  grant_tid;

  always #2.5 clk = ~clk;

  smt_fetch_sel uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int mcnt[4];
  bit msleep[4];
  logic [15:0] mwatch[4];
  int mptr;
  logic [15:0] addr_pool[4] = '{16'h1000, 16'h2040, 16'h3abc, 16'h0044};

  task automatic expect_out(output bit ev, output logic [3:0] eg, output int et);
    bit ok[4];
    int lo;
    ev = 0; eg = '0; et = 0; lo = 1000;
    for (int t = 0; t < 4; t++) begin
      ok[t] = !msleep[t] && (mcnt[t] < int'(cap));
      if (ok[t] && mcnt[t] < lo) lo = mcnt[t];
    end
    for (int k = 0; k < 4; k++) begin
      int j;
      j = (mptr + k) % 4;
      if (!ev && ok[j] && (rr_mode || mcnt[j] == lo)) begin
        ev = 1; eg[j] = 1'b1; et = j;
      end
    end
  endtask

  // Called after inputs are driven at a falling edge; checks, updates model, moves to next falling edge.
  task automatic step(input string req);
    bit ev; logic [3:0] eg; int et;
    #1;
    expect_out(ev, eg, et);
    n_chk++;
    if (fetch_valid !== ev || grant !== eg || int'(grant_tid) != et) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b grant=%b tid=%0d, expected valid=%0b grant=%b tid=%0d",
               req, fetch_valid, grant, grant_tid, ev, eg, et);
    end
    for (int t = 0; t < 4; t++) begin
      int v;
      v = mcnt[t];
      if (ev && fetch_ready && et == t) v += int'(fetch_num);
      if (ret_valid && int'(ret_tid) == t) v -= int'(ret_num);
      if (flush_valid && int'(flush_tid) == t) v -= int'(flush_num);
      if (v < 0) v = 0;
      if (v > 63) v = 63;
      mcnt[t] = v;
      if (quiesce_req && int'(quiesce_tid) == t) begin
        msleep[t] = 1; mwatch[t] = quiesce_addr;
      end else if (msleep[t] && mem_wr_valid && mem_wr_addr == mwatch[t]) begin
        msleep[t] = 0;
      end
    end
    if (ev && fetch_ready) mptr = (et + 1) % 4;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    fetch_ready = 0; fetch_num = 0;
    ret_valid = 0; ret_tid = 0; ret_num = 0;
    flush_valid = 0; flush_tid = 0; flush_num = 0;
    quiesce_req = 0; quiesce_tid = 0; quiesce_addr = 0;
    mem_wr_valid = 0; mem_wr_addr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; rr_mode = 0; cap = 6'd63;
    idle_inputs();
    for (int t = 0; t < 4; t++) begin mcnt[t] = 0; msleep[t] = 0; mwatch[t] = 0; end
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R9 no progress while ready is low
    step("R1");
    step("R9");
    step("R9");

    // R5 / R3: equal bundles into every thread, rotating ties
    fetch_ready = 1; fetch_num = 3'd4;
    repeat (8) step("R3");
    // R5: flush only thread 1
    fetch_ready = 0; flush_valid = 1; flush_tid = 2'd1; flush_num = 6'd5;
    step("R5");
    flush_valid = 0;
    step("R5");
    // R5: retire and fetch together on one thread
    fetch_ready = 1; fetch_num = 3'd2; ret_valid = 1; ret_tid = 2'd1; ret_num = 3'd4;
    repeat (3) step("R5");
    ret_valid = 0;
    // R5 saturation at 63
    cap = 6'd63; fetch_num = 3'd4;
    repeat (70) step("R5");
    // R6 drain, then small cap
    fetch_ready = 0; flush_valid = 1; fetch_num = 3'd4;
    for (int t = 0; t < 4; t++) begin flush_tid = 2'(t); flush_num = 6'd63; step("R5"); end
    flush_valid = 0;
    cap = 6'd5; fetch_ready = 1;
    repeat (10) step("R6");
    cap = 6'd0;
    step("R8");
    cap = 6'd40;
    // R7: quiesce every thread
    fetch_ready = 0;
    for (int t = 0; t < 4; t++) begin
      quiesce_req = 1; quiesce_tid = 2'(t); quiesce_addr = addr_pool[t]; step("R7");
    end
    quiesce_req = 0;
    step("R8");
    mem_wr_valid = 1; mem_wr_addr = 16'h7777;
    step("R8");
    mem_wr_addr = addr_pool[2];
    step("R7");
    mem_wr_valid = 0;
    step("R7");
    // R7: same-cycle quiesce and matching write keeps thread 2 asleep
    quiesce_req = 1; quiesce_tid = 2'd2; quiesce_addr = addr_pool[2];
    mem_wr_valid = 1; mem_wr_addr = addr_pool[2];
    step("R7");
    quiesce_req = 0; mem_wr_valid = 0;
    step("R8");
    for (int t = 0; t < 4; t++) begin
      mem_wr_valid = 1; mem_wr_addr = addr_pool[t]; step("R7");
    end
    mem_wr_valid = 0;
    // R4: round-robin ignores counts
    rr_mode = 1; fetch_ready = 1; fetch_num = 3'd1; cap = 6'd63;
    repeat (12) step("R4");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) rr_mode = ~rr_mode;
      if ($urandom_range(0, 99) < 5) cap = 6'($urandom_range(1, 63));
      fetch_ready  = ($urandom_range(0, 99) < 70);
      fetch_num    = 3'($urandom_range(0, 4));
      ret_valid    = ($urandom_range(0, 99) < 60);
      ret_tid      = 2'($urandom_range(0, 3));
      ret_num      = 3'($urandom_range(0, 4));
      flush_valid  = ($urandom_range(0, 99) < 8);
      flush_tid    = 2'($urandom_range(0, 3));
      flush_num    = 6'($urandom_range(0, 20));
      quiesce_req  = ($urandom_range(0, 99) < 5);
      quiesce_tid  = 2'($urandom_range(0, 3));
      quiesce_addr = addr_pool[$urandom_range(0, 3)];
      mem_wr_valid = ($urandom_range(0, 99) < 25);
      mem_wr_addr  = addr_pool[$urandom_range(0, 3)];
      step(rr_mode ? "R4" : "R2");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule